// File: doc/BRIEF.md
# General-Purpose I/O Port with Latch Readback

This block is one parameterised general-purpose I/O port on a simple single-cycle CPU register bus. Each pad bit is controlled by three registers. A direction register turns the pad output driver on or off. A data register at the port address reads back the synchronised pin levels. A second address reads back the stored output latch. A write to either address loads the same output latch. The block drives the pad output-enable and output-data lines and samples the pad input lines.

A constant mask of implemented bits trims the port for a given configuration. For a bit outside the mask, the output enable and output data are held inactive, and the bit reads as zero at all three addresses. Pad inputs pass through a two-flop synchroniser before they reach the port read path.

A bit-set or bit-clear done by software as read-modify-write through the port address copies the current pin level of every input bit into the latch. Doing the same operation through the latch address keeps the stored latch values intact.

Top module: `gpio_port`

## Requirements
- R1: On reset every direction bit is 1 (input), the output latch is all zeros, and `rd_data` is zero.
- R2: For a direction bit of 0, `pad_oe` is 1 and `pad_out` follows the latch bit. For a direction bit of 1, `pad_oe` is 0.
- R3: A write to address 1 (port) loads the output latch. A write to address 2 (latch) has the identical effect.
- R4: A read of address 1 returns the pin levels after the two-flop synchroniser, not the latch. A pad change shows up in the read data for a read issued two cycles after the change. The read data is registered and valid on the cycle after the read request.
- R5: A read of address 2 returns the latch contents, whatever the pin levels are.
- R6: A write to address 0 sets the direction register. A read of address 0 returns it.
- R7: Bits outside the implemented mask read as 0 at addresses 0, 1 and 2. They are never driven (`pad_oe` is 0 and `pad_out` is 0), and writes to them have no effect.
- R8: A read-modify-write through the port address copies the level of an input pin into the latch. The same operation through the latch address leaves that latch bit unchanged.
- R9: A read of address 3 returns zero, and a write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 direction, 1 port, 2 latch, 3 unused |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | WIDTH | Write data |
| rd_data | output | WIDTH | Registered read data |
| pad_in | input | WIDTH | Pad input levels |
| pad_oe | output | WIDTH | Pad output enable, 1 = drive |
| pad_out | output | WIDTH | Pad output data |

## Verification
The bench holds the pins opposite to the latch and then reads both data addresses. A design that wires the port read to the latch, or the latch read to the pins, returns the wrong pattern at one of them. It performs a set-bit read-modify-write through each address while an input pin sits high and the latch bit is low. A correct design shows the latch bit flipped only on the port-address path, so the hazard and its cure are both visible when the bit is later turned to an output. Unimplemented bits are written with ones at every address and must stay zero on reads and on the pad lines. A design that ignores the mask shows stray ones there. The bench also times the synchroniser latency: a read issued one cycle too early must still show the old pin level.

// File: rtl/gpio_pkg.sv
// Package: register addresses and the reset value of the direction register.
package gpio_pkg;
    typedef enum logic [1:0] {
        ADDR_DIR   = 2'd0,
        ADDR_PORT  = 2'd1,
        ADDR_LATCH = 2'd2,
        ADDR_NONE  = 2'd3
    } gpio_addr_e;

    localparam logic DIR_INPUT = 1'b1;
endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchroniser for pad inputs.
// Assumes pad inputs are asynchronous to clk and that each bit is independent.
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    // Two register stages per bit, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/gpio_bit.sv
// One pad bit: direction flop and output latch flop, plus pad drive.
// Assumes the write strobes are already decoded.
// An unimplemented bit (IMPL = 0) keeps constant state and never drives the pad.
module gpio_bit #(
    parameter bit IMPL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_dir,
    input  logic wr_lat,
    input  logic wdata,
    output logic dir_q,
    output logic lat_q,
    output logic oe,
    output logic dout
);
    import gpio_pkg::*;

    generate
        if (IMPL) begin : g_impl
            // Direction flop: resets to input.
            always_ff @(posedge clk) begin
                if (!rst_n)      dir_q <= DIR_INPUT;
                else if (wr_dir) dir_q <= wdata;
            end
            // Output latch: loaded by a port or latch write.
            always_ff @(posedge clk) begin
                if (!rst_n)      lat_q <= 1'b0;
                else if (wr_lat) lat_q <= wdata;
            end
            // Pad drive: enabled when the direction bit is 0.
            always_comb begin
                oe   = ~dir_q;
                dout = lat_q;
            end
        end else begin : g_absent
            // Absent bit: constant state, pad left idle.
            always_comb begin
                dir_q = 1'b0;
                lat_q = 1'b0;
                oe    = 1'b0;
                dout  = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_regs.sv
// Bus decode and registered read mux.
// Assumes a single-cycle bus and that reads and writes are not aligned to any other timing.
module gpio_regs #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_we,
    input  logic             bus_re,
    input  logic [WIDTH-1:0] impl_mask,
    input  logic [WIDTH-1:0] dir_v,
    input  logic [WIDTH-1:0] lat_v,
    input  logic [WIDTH-1:0] pin_v,
    output logic             wr_dir,
    output logic             wr_lat,
    output logic [WIDTH-1:0] rd_data
);
    import gpio_pkg::*;

    logic [WIDTH-1:0] rd_next;

    // Write strobe decode: the port and latch addresses share one strobe.
    always_comb begin
        wr_dir = bus_we && (bus_addr == ADDR_DIR);
        wr_lat = bus_we && ((bus_addr == ADDR_PORT) || (bus_addr == ADDR_LATCH));
    end

    // Read source select, masked to the implemented bits.
    always_comb begin
        unique case (gpio_addr_e'(bus_addr))
            ADDR_DIR:   rd_next = dir_v & impl_mask;
            ADDR_PORT:  rd_next = pin_v & impl_mask;
            ADDR_LATCH: rd_next = lat_v & impl_mask;
            default:    rd_next = '0;
        endcase
    end

    // Registered read data: updated on a read, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (bus_re) rd_data <= rd_next;
    end

    // R7: no unimplemented bit ever reads as 1.
    a_r7_rd_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~impl_mask) == '0);
    // R9: a read of the unused address returns zero.
    a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == 2'd3) |=> rd_data == '0);
    // R4: the read data changes only on the cycle after a read.
    a_r4_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(rd_data));
endmodule

// File: rtl/gpio_port.sv
// Top of the GPIO port.
// Assumes IMPL_MASK is fixed at build time. Bits outside the mask are absent.
module gpio_port #(
    parameter int          WIDTH     = 8,
    parameter logic [WIDTH-1:0] IMPL_MASK = 8'h7F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_we,
    input  logic             bus_re,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out
);
    localparam logic [WIDTH-1:0] MASK = IMPL_MASK;

    logic             wr_dir, wr_lat;
    logic [WIDTH-1:0] dir_v, lat_v, pin_v;

    gpio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pin_v)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .impl_mask(MASK), .dir_v(dir_v), .lat_v(lat_v),
        .pin_v(pin_v), .wr_dir(wr_dir), .wr_lat(wr_lat), .rd_data(rd_data)
    );

    // One bit cell per pad. The mask decides whether the cell is built.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            gpio_bit #(.IMPL(MASK[i])) u_bit (
                .clk(clk), .rst_n(rst_n), .wr_dir(wr_dir), .wr_lat(wr_lat),
                .wdata(bus_wdata[i]), .dir_q(dir_v[i]), .lat_q(lat_v[i]),
                .oe(pad_oe[i]), .dout(pad_out[i])
            );
        end
    endgenerate

    // R7: absent pads are never driven.
    a_r7_pad_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_out) & ~MASK) == '0);
    // R3: a latch-path write shows on the pad data on the next cycle.
    a_r3_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == 2'd1 || bus_addr == 2'd2)) |=> pad_out == ($past(bus_wdata) & MASK));
    // R6: the pad enable follows a direction write.
    a_r6_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd0) |=> pad_oe == (~$past(bus_wdata) & MASK));
    // R9: a write to the unused address leaves the pads unchanged.
    a_r9_unused_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd3) |=> ($stable(pad_oe) && $stable(pad_out)));
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    localparam int W = 8;
    localparam logic [W-1:0] M = 8'h7F;

    logic clk = 0, rst_n = 0;
    logic [1:0] bus_addr = 0;
    logic bus_we = 0, bus_re = 0;
    logic [W-1:0] bus_wdata = 0, rd_data, pad_in = 0, pad_oe, pad_out;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    gpio_port #(.WIDTH(W), .IMPL_MASK(M)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive inputs on the falling edge so they are settled before the next rising edge.
    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk); bus_we = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        @(negedge clk); bus_addr = a; bus_re = 1;
        @(negedge clk); bus_re = 0; d = rd_data;
    endtask

    task automatic t_reset();
        logic [W-1:0] d;
        check("R1 rd_data", rd_data, '0);
        check("R1 pad_oe", pad_oe, '0);
        rd(2'd0, d); check("R1 dir", d, M);
        rd(2'd2, d); check("R1 latch", d, '0);
    endtask

    task automatic t_dir_latch();
        logic [W-1:0] d;
        wr(2'd0, 8'h0F); rd(2'd0, d); check("R6 dir rd", d, 8'h0F);
        check("R2 oe", pad_oe, 8'h70);
        wr(2'd1, 8'h5A); check("R3 port wr", pad_out, 8'h5A);
        check("R2 oe unchanged", pad_oe, 8'h70);
        wr(2'd2, 8'h25); check("R3 latch wr", pad_out, 8'h25);
    endtask

    task automatic t_read_paths();
        logic [W-1:0] d;
        wr(2'd2, 8'h33);
        @(negedge clk); pad_in = 8'hCC;
        repeat (3) @(negedge clk);
        rd(2'd1, d); check("R4 port pins", d, 8'h4C);
        rd(2'd2, d); check("R5 latch", d, 8'h33);
        // Latency: change the pad, then read two cycles later.
        pad_in = 8'h11;
        @(negedge clk); bus_addr = 2'd1; bus_re = 1;
        @(negedge clk); bus_re = 0; check("R4 early old", rd_data, 8'h4C);
        @(negedge clk); bus_re = 1;
        @(negedge clk); bus_re = 0; check("R4 sync new", rd_data, 8'h11);
    endtask

    task automatic t_mask();
        logic [W-1:0] d;
        wr(2'd0, 8'h00); wr(2'd2, 8'hFF);
        check("R7 pad_oe", pad_oe, 8'h7F);
        check("R7 pad_out", pad_out, 8'h7F);
        pad_in = 8'hFF; repeat (3) @(negedge clk);
        rd(2'd0, d); check("R7 dir", d, 8'h00);
        rd(2'd1, d); check("R7 port", d, 8'h7F);
        rd(2'd2, d); check("R7 latch", d, 8'h7F);
    endtask

    task automatic t_unused();
        logic [W-1:0] d;
        wr(2'd0, 8'hF0); wr(2'd2, 8'h05);
        wr(2'd3, 8'hAA);
        rd(2'd3, d); check("R9 read", d, '0);
        rd(2'd0, d); check("R9 dir kept", d, 8'h70);
        rd(2'd2, d); check("R9 latch kept", d, 8'h05);
    endtask

    task automatic t_rmw();
        logic [W-1:0] d;
        // Bit 4 is an input held high with its latch low. Set bit 0 through each path.
        wr(2'd0, 8'h7E); wr(2'd2, 8'h00);
        pad_in = 8'h10; repeat (3) @(negedge clk);
        rd(2'd1, d); wr(2'd1, d | 8'h01);
        rd(2'd2, d); check("R8 port rmw copies pin", d, 8'h11);
        wr(2'd2, 8'h00);
        rd(2'd2, d); wr(2'd2, d | 8'h01);
        rd(2'd2, d); check("R8 latch rmw clean", d, 8'h01);
        wr(2'd0, 8'h00); check("R8 pad_out", pad_out, 8'h01);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                @(negedge clk);
                t_reset(); t_dir_latch(); t_read_paths();
                t_mask(); t_unused(); t_rmw();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule